// File: doc/BRIEF.md
# Display Data Channel Wake-Up Sequencer

This block conditions the two open-drain lines of a display data channel before the 128-byte display identification block is fetched, and again after the fetch. Some legacy monitors only answer once this ritual has run. The block owns two pull-down enables, one for the clock line and one for the data line. It also watches the clock line as seen on the wire, so it can tell when an attached monitor has stopped holding the clock low.

The byte transfer itself is handed to an external I2C byte master through a one-cycle start pulse and a done/ok reply. That master writes offset 0x00 to 7-bit address 0x50 and then reads 128 bytes. It reports ok only when both messages complete.

All waits count pulses of a microsecond tick input. Every wait length, poll limit and the attempt limit is a parameter, so a short simulation can use small values. After a run the block pulses done and holds the ok flag until the next start.

Top module: `ddc_wake_seq`

## Requirements
- R1: After reset both pull-down enables are off, and busy, done and the transfer start pulse are all low.
- R2: On start the clock enable is turned off while the data enable keeps its value, for T_STARTUP ticks. After that both enables turn on.
- R3: Each attempt holds the data enable on for T_SDA_LOW ticks, with the clock enable left as it was, and then turns the clock enable off.
- R4: Once the clock is released, the clock line is sampled every T_POLL ticks, at most WAKE_POLLS times. If it is never seen high, the attempt is abandoned and the clock stays released.
- R5: Once the clock is seen high, the block holds the data enable on for T_HOLD ticks, then adds the clock enable for T_HOLD ticks, then turns the data enable off for T_HOLD ticks. It then raises the transfer start for one cycle, with the clock enable on and the data enable off.
- R6: The transfer start is a single-cycle pulse. No further pulse is issued until done is returned. The ok input sampled with done is the transfer result.
- R7: After each transfer both enables are on for T_HOLD ticks. Then the clock is released and sampled every T_POLL ticks, stopping when it is seen high or after POST_POLLS samples. The data enable is then off for T_HOLD ticks, and finally the clock enable is turned on.
- R8: The retry loop stops at the first successful transfer, and at most ATTEMPTS attempts are made.
- R9: At the end both enables are on for T_HOLD ticks. Then the clock enable turns off, leaving the data enable on, and done pulses for one cycle with busy low.
- R10: If no attempt produced a successful transfer, ok is low when done pulses.
- R11: Wait lengths count tick pulses only, whatever the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle microsecond tick |
| start_i | input | 1 | Begin a sequence (accepted when idle) |
| scl_i | input | 1 | Clock line level as seen on the wire |
| xfer_done_i | input | 1 | Byte master finished the transfer |
| xfer_ok_i | input | 1 | Transfer result, valid with xfer_done_i |
| scl_low_o | output | 1 | Pull the clock line low |
| sda_low_o | output | 1 | Pull the data line low |
| xfer_start_o | output | 1 | One-cycle request to the byte master |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Result of the last sequence |

## Verification
A wait that ends on a tick changes the line enables at the next clock edge, one register after the timer reaches zero. The transfer start comes one cycle after the data-release wait expires. The done pulse comes one cycle after the final wait, in the same cycle as the clock release.

The bench samples on falling edges and splits the run into segments of constant line state. For each segment it counts the ticks it issued itself. Because no tick falls on the cycle between the timer reaching zero and the lines changing, each count must equal the arithmetic sum of the waits expected in that segment. Clock polls come out as multiples of T_POLL, set by a bench model of a monitor that holds the clock for a chosen number of ticks.

// File: rtl/ddc_wake_pkg.sv
package ddc_wake_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STARTUP,
    ST_ATT_SDA,
    ST_WAKE_POLL,
    ST_PRE_SDA,
    ST_PRE_SCL,
    ST_PRE_REL,
    ST_XFER,
    ST_POST_LOW,
    ST_POST_POLL,
    ST_POST_REL,
    ST_FIN
  } ddc_state_e;
endpackage

// File: rtl/ddc_tick_timer.sv
module ddc_tick_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R11
  tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ddc_step_ctr.sv
module ddc_step_ctr #(
  parameter int W   = 2,
  parameter int MAX = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (inc_i)  q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;

  // R8
  ctr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_q) < MAX);
endmodule

// File: rtl/ddc_wake_seq.sv
module ddc_wake_seq
  import ddc_wake_pkg::*;
#(
  parameter int T_STARTUP  = 550,
  parameter int T_SDA_LOW  = 13000,
  parameter int T_POLL     = 10000,
  parameter int T_HOLD     = 15000,
  parameter int WAKE_POLLS = 5,
  parameter int POST_POLLS = 10,
  parameter int ATTEMPTS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic scl_i,
  input  logic xfer_done_i,
  input  logic xfer_ok_i,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic xfer_start_o,
  output logic busy_o,
  output logic done_o,
  output logic ok_o
);
  localparam int TM_A = (T_STARTUP > T_SDA_LOW) ? T_STARTUP : T_SDA_LOW;
  localparam int TM_B = (T_POLL > T_HOLD) ? T_POLL : T_HOLD;
  localparam int TMAX = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PMAX = (WAKE_POLLS > POST_POLLS) ? WAKE_POLLS : POST_POLLS;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int AW   = $clog2(ATTEMPTS + 1);

  ddc_state_e st_q, st_d;
  logic scl_q, scl_d, sda_q, sda_d;
  logic ok_q, ok_d, done_q, done_d, xs_q, xs_d;
  logic ld, t_zero;
  logic [TW-1:0] ld_val;
  logic att_clr, att_inc, pol_clr, pol_inc;
  logic [AW-1:0] att_q;
  logic [PW-1:0] pol_q;
  logic last_att;

  ddc_tick_timer #(.W(TW)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_val),
    .tick_i(tick_i), .zero_o(t_zero)
  );

  ddc_step_ctr #(.W(AW), .MAX(ATTEMPTS)) att_ctr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(att_clr), .inc_i(att_inc), .q_o(att_q)
  );

  ddc_step_ctr #(.W(PW), .MAX(PMAX)) pol_ctr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pol_clr), .inc_i(pol_inc), .q_o(pol_q)
  );

  assign last_att = (att_q == AW'(ATTEMPTS - 1));

  always_comb begin
    st_d    = st_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    ok_d    = ok_q;
    done_d  = 1'b0;
    xs_d    = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    att_clr = 1'b0;
    att_inc = 1'b0;
    pol_clr = 1'b0;
    pol_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_STARTUP; scl_d = 1'b0; ok_d = 1'b0; att_clr = 1'b1;
        ld = 1'b1; ld_val = TW'(T_STARTUP);
      end
      ST_STARTUP: if (t_zero) begin
        st_d = ST_ATT_SDA; scl_d = 1'b1; sda_d = 1'b1;
        ld = 1'b1; ld_val = TW'(T_SDA_LOW);
      end
      ST_ATT_SDA: if (t_zero) begin
        st_d = ST_WAKE_POLL; scl_d = 1'b0; pol_clr = 1'b1;
        ld = 1'b1; ld_val = TW'(T_POLL);
      end
      ST_WAKE_POLL: if (t_zero) begin
        if (scl_i) begin
          st_d = ST_PRE_SDA; sda_d = 1'b1;
          ld = 1'b1; ld_val = TW'(T_HOLD);
        end else if (pol_q == PW'(WAKE_POLLS - 1)) begin
          // attempt abandoned, clock stays released
          sda_d = 1'b1; ld = 1'b1;
          if (last_att) begin
            st_d = ST_FIN; scl_d = 1'b1; ld_val = TW'(T_HOLD);
          end else begin
            st_d = ST_ATT_SDA; att_inc = 1'b1; ld_val = TW'(T_SDA_LOW);
          end
        end else begin
          pol_inc = 1'b1; ld = 1'b1; ld_val = TW'(T_POLL);
        end
      end
      ST_PRE_SDA: if (t_zero) begin
        st_d = ST_PRE_SCL; scl_d = 1'b1;
        ld = 1'b1; ld_val = TW'(T_HOLD);
      end
      ST_PRE_SCL: if (t_zero) begin
        st_d = ST_PRE_REL; sda_d = 1'b0;
        ld = 1'b1; ld_val = TW'(T_HOLD);
      end
      ST_PRE_REL: if (t_zero) begin
        st_d = ST_XFER; xs_d = 1'b1;
      end
      ST_XFER: if (xfer_done_i) begin
        st_d = ST_POST_LOW; ok_d = xfer_ok_i; scl_d = 1'b1; sda_d = 1'b1;
        ld = 1'b1; ld_val = TW'(T_HOLD);
      end
      ST_POST_LOW: if (t_zero) begin
        st_d = ST_POST_POLL; scl_d = 1'b0; pol_clr = 1'b1;
        ld = 1'b1; ld_val = TW'(T_POLL);
      end
      ST_POST_POLL: if (t_zero) begin
        if (scl_i || pol_q == PW'(POST_POLLS - 1)) begin
          st_d = ST_POST_REL; sda_d = 1'b0;
          ld = 1'b1; ld_val = TW'(T_HOLD);
        end else begin
          pol_inc = 1'b1; ld = 1'b1; ld_val = TW'(T_POLL);
        end
      end
      ST_POST_REL: if (t_zero) begin
        scl_d = 1'b1; sda_d = 1'b1; ld = 1'b1;
        if (ok_q || last_att) begin
          st_d = ST_FIN; ld_val = TW'(T_HOLD);
        end else begin
          st_d = ST_ATT_SDA; att_inc = 1'b1; ld_val = TW'(T_SDA_LOW);
        end
      end
      ST_FIN: if (t_zero) begin
        st_d = ST_IDLE; scl_d = 1'b0; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
      xs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      ok_q   <= ok_d;
      done_q <= done_d;
      xs_q   <= xs_d;
    end
  end

  assign scl_low_o    = scl_q;
  assign sda_low_o    = sda_q;
  assign xfer_start_o = xs_q;
  assign done_o       = done_q;
  assign ok_o         = ok_q;
  assign busy_o       = (st_q != ST_IDLE);

  // R6
  xfer_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  // R5
  xfer_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (scl_low_o && !sda_low_o));
  // R9
  done_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scl_low_o && sda_low_o && !busy_o));
  // R4
  wake_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE_POLL) |-> (!scl_low_o && sda_low_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/ddc_wake_seq_tb_top.sv
module ddc_wake_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TSU = 5, TSDA = 5, TP = 4, TH = 3, WP = 5, PP = 10, ATT = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0, scl_i = 1'b1;
  logic xfer_done_i = 1'b0, xfer_ok_i = 1'b0;
  logic scl_low_o, sda_low_o, xfer_start_o, busy_o, done_o, ok_o;

  ddc_wake_seq #(
    .T_STARTUP(TSU), .T_SDA_LOW(TSDA), .T_POLL(TP), .T_HOLD(TH),
    .WAKE_POLLS(WP), .POST_POLLS(PP), .ATTEMPTS(ATT)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .scl_i(scl_i), .xfer_done_i(xfer_done_i), .xfer_ok_i(xfer_ok_i),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .xfer_start_o(xfer_start_o),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, bad = 0;
  int e_n, o_n, exp_ok, exp_nx, hold;
  int e_s[64], e_d[64], e_t[64];
  string e_g[64];
  int o_s[64], o_d[64], o_t[64];

  task automatic chk_eq(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // append a line segment; equal line state merges, -1 ticks = don't care
  task automatic push(input int s, input int d, input int t, input string g);
    if (e_n > 0 && e_s[e_n-1] == s && e_d[e_n-1] == d) begin
      if (e_t[e_n-1] < 0 || t < 0) e_t[e_n-1] = -1;
      else e_t[e_n-1] += t;
    end else if (e_n < 64) begin
      e_s[e_n] = s; e_d[e_n] = d; e_t[e_n] = t; e_g[e_n] = g; e_n++;
    end
  endtask

  task automatic build(input int hw, input int hp, input bit [2:0] okv);
    int cur_scl, rel, k;
    bit seen;
    e_n = 0; exp_ok = 0; exp_nx = 0;
    push(0, 0, TSU, "R2");
    cur_scl = 1; rel = 0;
    for (int a = 0; a < ATT; a++) begin
      push(cur_scl, 1, TSDA, "R3");
      if (cur_scl == 1) rel = 0; else rel += TSDA;
      seen = 0; k = 0;
      for (int p = 1; p <= WP; p++) begin
        rel += TP; k = p;
        if (rel >= hw) begin seen = 1; break; end
      end
      push(0, 1, k*TP, "R4");
      cur_scl = 0;
      if (!seen) continue;
      push(0, 1, TH, "R5");
      push(1, 1, TH, "R5");
      push(1, 0, -1, "R6");
      exp_nx++;
      push(1, 1, TH, "R7");
      rel = 0; k = 0;
      for (int p = 1; p <= PP; p++) begin
        rel += TP; k = p;
        if (rel >= hp) break;
      end
      push(0, 1, k*TP, "R7");
      push(0, 0, TH, "R7");
      cur_scl = 1;
      if (okv[a]) begin exp_ok = 1; break; end
    end
    push(1, 1, TH, "R9");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 1'b0; tick_i = 1'b0; xfer_done_i = 1'b0;
    xfer_ok_i = 1'b0; scl_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run_case(input int hw, input int hp, input bit [2:0] okv,
                          input int div, input string tover);
    int cyc = 0, cnt = 0, rel = 0, pend = 0, nx = 0, bad_start = 0;
    int cur_s = 0, cur_d = 0, lim;
    bit mon = 0, fin = 0;
    string tg;
    do_reset();
    build(hw, hp, okv);
    hold = hw; o_n = 0;
    while (!fin && cyc < 20000) begin
      @(negedge clk_i);
      cyc++;
      start_i = (cyc == 1);
      if (cyc == 2) begin
        mon = 1; cur_s = int'(scl_low_o); cur_d = int'(sda_low_o); cnt = 0;
      end else if (mon && (int'(scl_low_o) != cur_s || int'(sda_low_o) != cur_d)) begin
        if (o_n < 64) begin o_s[o_n] = cur_s; o_d[o_n] = cur_d; o_t[o_n] = cnt; end
        o_n++;
        cur_s = int'(scl_low_o); cur_d = int'(sda_low_o); cnt = 0;
      end
      if (mon && done_o) fin = 1;
      xfer_done_i = 1'b0;
      if (pend > 0) begin
        if (xfer_start_o) bad_start++;
        pend--;
        if (pend == 0) begin
          xfer_done_i = 1'b1;
          xfer_ok_i = okv[nx-1];
          hold = hp;
        end
      end else if (xfer_start_o) begin
        nx++; pend = 3;
      end
      tick_i = (cyc % div == 0);
      if (scl_low_o) rel = 0;
      else if (tick_i) rel++;
      scl_i = !scl_low_o && (rel >= hold);
      if (mon && tick_i) cnt++;
    end
    tick_i = 1'b0;
    chk_eq("R8", "sequence finished", int'(fin), 1);
    chk_eq("R9", "clock released at end", int'(scl_low_o), 0);
    chk_eq("R9", "data held low at end", int'(sda_low_o), 1);
    chk_eq("R9", "busy low with done", int'(busy_o), 0);
    chk_eq(exp_ok ? "R8" : "R10", "ok flag", int'(ok_o), exp_ok);
    chk_eq("R8", "transfer count", nx, exp_nx);
    chk_eq("R6", "start pulses while pending", bad_start, 0);
    chk_eq("R3", "segment count", o_n, e_n);
    lim = (o_n < e_n) ? o_n : e_n;
    if (lim > 64) lim = 64;
    for (int i = 0; i < lim; i++) begin
      tg = (tover != "") ? tover : e_g[i];
      chk_eq(tg, $sformatf("seg %0d lines", i), o_s[i]*2 + o_d[i], e_s[i]*2 + e_d[i]);
      if (e_t[i] >= 0)
        chk_eq(tg, $sformatf("seg %0d ticks", i), o_t[i], e_t[i]);
    end
    @(negedge clk_i);
    chk_eq("R9", "done single pulse", int'(done_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    total++; bad++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk_eq("R1", "clock enable", int'(scl_low_o), 0);
    chk_eq("R1", "data enable", int'(sda_low_o), 0);
    chk_eq("R1", "busy", int'(busy_o), 0);
    chk_eq("R1", "done", int'(done_o), 0);
    chk_eq("R1", "xfer start", int'(xfer_start_o), 0);
    run_case(0, 0, 3'b001, 3, "");     // first attempt succeeds
    run_case(6, 6, 3'b100, 3, "");     // stretched clock, third attempt succeeds
    run_case(6, 6, 3'b000, 3, "R10");  // all transfers fail
    run_case(100, 100, 3'b000, 3, "R4"); // clock never released by monitor
    run_case(0, 60, 3'b001, 3, "R7");  // post poll exhausts its limit
    run_case(0, 0, 3'b001, 5, "R11");  // slower tick rate, same tick counts
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule